// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual page number into a physical page number after a translation cache miss. It accepts one translation request at a time, holding the virtual page number, the untranslated page offset and the kind of access. It then reads one 64-bit table entry per level from memory, descending through three tables. The first table's page number comes from a base input sampled when the request is accepted.

Every table fills exactly one 8 KB page of 1024 eight-byte entries, so each level consumes ten bits of the virtual page number. The walk stops early when an entry is not valid. At the last level, the access kind is compared with the entry's protection bits. The result is a one-cycle response carrying either the translated page number and the physical address, or a fault code that software acts on.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: Only one walk runs at a time. `req_ready` is 1 only while idle and drops in the cycle after a request is accepted. It stays low until after the response cycle, and requests offered meanwhile are ignored and produce no response.
- R3: The read for level L (0 = root) uses address {table_ppn, idx_L, 3'b000}. Here idx_0 = vpn[29:20], idx_1 = vpn[19:10] and idx_2 = vpn[9:0]. The root table_ppn is `ptbr` as sampled at acceptance, and each deeper table_ppn is bits [63:32] of the previous entry.
- R4: Once `mem_req_valid` rises, it stays high with `mem_req_addr` unchanged until a cycle in which `mem_req_ready` is 1. The entry is taken from `mem_rsp_data` in a cycle with `mem_rsp_valid` set.
- R5: Entry layout: bit0 valid, bit1 read, bit2 write, bit3 execute, bit4 modified, bits[6:5] caching policy, bits[63:32] page number. On success, `rsp_ppn` is the leaf entry's bits [63:32].
- R6: An entry with bit0 clear at any level ends the walk with `rsp_fault`=1, `rsp_cause`=2'b01 and `rsp_level` set to that level. No further memory reads are made for that walk.
- R7: At the last level, access code 00 (load) needs the read bit, 01 (store) needs write, 10 (fetch) needs execute and 11 (read-modify-write) needs both read and write. A missing right gives `rsp_fault`=1, `rsp_cause`=2'b10 and `rsp_level`=2. Protection bits of the first two levels have no effect.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. `rsp_state` carries bits [7:0] of the entry that ended the walk. On success `rsp_fault`=0, `rsp_cause`=2'b00 and `rsp_level`=2.
- R9: `rsp_paddr` is {rsp_ppn, offset}, with the offset as given at acceptance. On a fault, `rsp_ppn` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_vpn | input | 30 | Virtual page number |
| req_off | input | 13 | Page offset, passed through |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 read-modify-write |
| ptbr | input | 32 | Page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 45 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 00 none, 01 invalid entry, 10 protection |
| rsp_level | output | 2 | Level where the walk ended |
| rsp_ppn | output | 32 | Translated page number |
| rsp_state | output | 8 | Low byte of the final entry |
| rsp_paddr | output | 45 | Physical address |

## Verification
Several properties are checked on every cycle: the request port stays closed while the memory port is in use, a stalled read holds its address, the response lasts one cycle, and faulting responses carry a zero page number. Other behaviour can only be shown by the bench's scenarios, because each depends on table contents chosen by the bench. This covers the index chosen at each level, early termination on an invalid entry, the access-kind-to-right mapping at the leaf, the indifference to intermediate rights, and the sampling of the base input and offset at acceptance.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS = 3,
  parameter int OFF_W  = 13,
  parameter int PPN_W  = 32,
  localparam int IDX_W = OFF_W - 3,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int PTE_W = 64,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic [PPN_W-1:0] ptbr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [LVL_W-1:0] rsp_level,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [7:0]       rsp_state,
  output logic [PA_W-1:0]  rsp_paddr
);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, DONE} st_t;

  st_t              st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic [PPN_W-1:0] tbl_q, ppn_q;
  logic [7:0]       state_q;
  logic [1:0]       cause_q;
  logic [LVL_W-1:0] end_lvl_q;

  logic [VPN_W-1:0] idx_sh;
  logic [IDX_W-1:0] idx;
  logic             pv, pr, pw, px, perm_ok, last;
  logic             unused_pte;

  assign idx_sh = vpn_q >> (IDX_W * (LEVELS - 1 - int'(lvl_q)));
  assign idx    = idx_sh[IDX_W-1:0];
  assign last   = (lvl_q == LVL_W'(LEVELS - 1));

  assign pv = mem_rsp_data[0];
  assign pr = mem_rsp_data[1];
  assign pw = mem_rsp_data[2];
  assign px = mem_rsp_data[3];
  assign unused_pte = ^mem_rsp_data[PTE_W-PPN_W-1:8];

  always_comb begin
    case (acc_q)
      2'b00:   perm_ok = pr;
      2'b01:   perm_ok = pw;
      2'b10:   perm_ok = px;
      default: perm_ok = pr & pw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= IDLE;
      lvl_q     <= '0;
      vpn_q     <= '0;
      off_q     <= '0;
      acc_q     <= '0;
      tbl_q     <= '0;
      ppn_q     <= '0;
      state_q   <= '0;
      cause_q   <= '0;
      end_lvl_q <= '0;
    end else begin
      case (st_q)
        IDLE: if (req_valid) begin
          vpn_q <= req_vpn;
          off_q <= req_off;
          acc_q <= req_acc;
          tbl_q <= ptbr;
          lvl_q <= '0;
          st_q  <= ISSUE;
        end
        ISSUE: if (mem_req_ready) st_q <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          state_q   <= mem_rsp_data[7:0];
          end_lvl_q <= lvl_q;
          ppn_q     <= '0;
          cause_q   <= 2'b00;
          if (!pv) begin
            cause_q <= 2'b01;
            st_q    <= DONE;
          end else if (!last) begin
            tbl_q <= mem_rsp_data[PTE_W-1 -: PPN_W];
            lvl_q <= lvl_q + 1'b1;
            st_q  <= ISSUE;
          end else if (!perm_ok) begin
            cause_q <= 2'b10;
            st_q    <= DONE;
          end else begin
            ppn_q <= mem_rsp_data[PTE_W-1 -: PPN_W];
            st_q  <= DONE;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == IDLE);
  assign mem_req_valid = (st_q == ISSUE);
  assign mem_req_addr  = {tbl_q, idx, 3'b000};
  assign rsp_valid     = (st_q == DONE);
  assign rsp_fault     = (cause_q != 2'b00);
  assign rsp_cause     = cause_q;
  assign rsp_level     = end_lvl_q;
  assign rsp_ppn       = ppn_q;
  assign rsp_state     = state_q;
  assign rsp_paddr     = {ppn_q, off_q};

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 45,
  parameter int PPN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PPN_W-1:0] rsp_ppn
);

  a_r2_closed_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r2_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_quiet_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_req_valid && !req_ready));

  a_r9_fault_zero_ppn: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_ppn == '0));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_ppn(rsp_ppn)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [29:0] req_vpn = 0;
  logic [12:0] req_off = 0;
  logic [1:0]  req_acc = 0;
  logic [31:0] ptbr = 0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = 0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause, rsp_level;
  logic [31:0] rsp_ppn;
  logic [7:0]  rsp_state;
  logic [44:0] rsp_paddr;

  pt_walker uut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  cause;
    logic [1:0]  lvl;
    logic [31:0] ppn;
    logic [7:0]  state;
    logic [44:0] paddr;
  } exp_t;

  exp_t        sb_q[$];
  logic [44:0] addr_q[$];
  logic [63:0] mem [logic [44:0]];
  int n_chk = 0, n_fail = 0, n_exp = 0, n_rsp = 0, cyc = 0;

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FM = 8'h10;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [44:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] pte(input logic [31:0] ppn, input logic [7:0] fl);
    return {ppn, 24'd0, fl};
  endfunction

  function automatic logic [44:0] ea(input logic [31:0] t, input logic [9:0] i);
    return {t, i, 3'b000};
  endfunction

  task automatic map3(input logic [31:0] root, input logic [29:0] v,
                      input logic [31:0] t1, input logic [31:0] t2, input logic [63:0] leaf);
    mem[ea(root, v[29:20])] = pte(t1, FV);
    mem[ea(t1, v[19:10])]   = pte(t2, FV);
    mem[ea(t2, v[9:0])]     = leaf;
  endtask

  task automatic walk(input logic [29:0] v, input logic [12:0] off,
                      input logic [1:0] acc, input bit hold);
    exp_t e;
    logic [31:0] t;
    logic [63:0] p;
    logic ok;
    t = ptbr;
    e = '0;
    for (int l = 0; l < 3; l++) begin
      logic [9:0] i;
      i = 10'(v >> (10 * (2 - l)));
      addr_q.push_back(ea(t, i));
      p = rd(ea(t, i));
      e.lvl = 2'(l);
      e.state = p[7:0];
      if (!p[0]) begin e.cause = 2'b01; break; end
      if (l < 2) t = p[63:32];
      else begin
        case (acc)
          2'b00: ok = p[1];
          2'b01: ok = p[2];
          2'b10: ok = p[3];
          default: ok = p[1] & p[2];
        endcase
        if (ok) e.ppn = p[63:32];
        else e.cause = 2'b10;
      end
    end
    e.paddr = {e.ppn, off};
    sb_q.push_back(e);
    n_exp++;
    do @(negedge clk); while (!req_ready);
    req_valid = 1; req_vpn = v; req_off = off; req_acc = acc;
    @(negedge clk);
    if (hold) begin
      logic [31:0] saved;
      saved = ptbr;
      req_vpn = ~v; req_off = ~off; req_acc = ~acc; ptbr = 32'h999;
      repeat (3) @(negedge clk);
      ptbr = saved;
    end
    req_valid = 0;
    do @(negedge clk); while (!req_ready);
  endtask

  // memory model, driven at the falling edge
  initial begin
    bit pend = 0;
    int pcnt = 0;
    logic [44:0] paddr = 0;
    bit stalled = 0;
    logic [44:0] st_addr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (stalled) chk(mem_req_valid && mem_req_addr == st_addr, "R4 stalled read held",
                       {19'd0, mem_req_addr}, {19'd0, st_addr});
      mem_rsp_valid = 0;
      if (pend) begin
        if (pcnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = rd(paddr); pend = 0; end
        else pcnt--;
      end
      mem_req_ready = (cyc % 3) != 1;
      stalled = mem_req_valid && !mem_req_ready;
      st_addr = mem_req_addr;
      if (mem_req_valid) chk(!req_ready, "R2 ready low during walk", {63'd0, req_ready}, 64'd0);
      if (mem_req_valid && mem_req_ready && rst_n) begin
        logic [44:0] ex;
        ex = (addr_q.size() != 0) ? addr_q.pop_front() : 45'h1FFF_FFFF_FFFF;
        chk(mem_req_addr == ex, "R3 entry address", {19'd0, mem_req_addr}, {19'd0, ex});
        pend = 1; paddr = mem_req_addr; pcnt = cyc % 3;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        exp_t e;
        n_rsp++;
        if (sb_q.size() == 0) chk(0, "R2 unexpected response", 64'd1, 64'd0);
        else begin
          e = sb_q.pop_front();
          chk(rsp_cause == e.cause && rsp_fault == (e.cause != 0), "R7 cause/fault",
              {61'd0, rsp_fault, rsp_cause}, {61'd0, e.cause != 0, e.cause});
          chk(rsp_level == e.lvl, "R6 level", 64'(rsp_level), 64'(e.lvl));
          chk(rsp_ppn == e.ppn, "R5 ppn", 64'(rsp_ppn), 64'(e.ppn));
          chk(rsp_state == e.state, "R8 state", 64'(rsp_state), 64'(e.state));
          chk(rsp_paddr == e.paddr, "R9 paddr", 64'(rsp_paddr), 64'(e.paddr));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R2 watchdog", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_P * 2 + 1);
    chk(req_ready == 1 && mem_req_valid == 0 && rsp_valid == 0, "R1 reset outputs",
        {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'd4);
    rst_n = 1;

    ptbr = 32'h100;
    map3(32'h100, {10'd3, 10'd5, 10'd7}, 32'h200, 32'h300, pte(32'hABCD, FV | FR | FM | 8'h40));
    mem[ea(32'h200, 10'd6)] = pte(32'h301, FV);
    mem[ea(32'h301, 10'd9)] = pte(32'h1234, FV | FX);
    mem[ea(32'h300, 10'd8)] = pte(32'h77, FR | FW);
    mem[ea(32'h300, 10'd10)] = pte(32'h88, FV | FW);
    map3(32'h100, 30'h3FFF_FFFF, 32'h400, 32'h401, pte(32'hFFFF_FFFF, FV | FR | FW | FM | 8'h60));
    map3(32'h100, 30'd0, 32'h500, 32'h501, pte(32'h42, FV | FR));
    map3(32'h600, {10'd3, 10'd5, 10'd7}, 32'h700, 32'h701, pte(32'h5555, FV | FR));

    walk({10'd3, 10'd5, 10'd7}, 13'h123, 2'b00, 0);  // R5 R8 load success
    walk({10'd3, 10'd5, 10'd7}, 13'h0,   2'b01, 0);  // R7 store without write right
    walk({10'd3, 10'd6, 10'd9}, 13'h55,  2'b10, 0);  // R7 fetch with execute
    walk({10'd3, 10'd6, 10'd9}, 13'h55,  2'b00, 0);  // R7 load without read
    walk(30'h3FFF_FFFF,         13'h1FFF, 2'b11, 0); // R3 R9 top indices, rmw ok
    walk(30'd0,                 13'h0,   2'b11, 0);  // R7 rmw missing write
    walk({10'd9, 10'd0, 10'd0}, 13'h7,   2'b00, 0);  // R6 invalid at root
    walk({10'd3, 10'd7, 10'd0}, 13'h7,   2'b00, 0);  // R6 invalid at level 1
    walk({10'd3, 10'd5, 10'd8}, 13'h7,   2'b00, 0);  // R6 invalid leaf with rights
    walk({10'd3, 10'd5, 10'd10}, 13'h9,  2'b01, 0);  // R7 intermediate rights ignored
    walk({10'd3, 10'd5, 10'd7}, 13'h321, 2'b00, 1);  // R2 R3 held request, base changed
    ptbr = 32'h600;
    walk({10'd3, 10'd5, 10'd7}, 13'h11,  2'b00, 0);  // R3 other root

    repeat (10) @(negedge clk);
    chk(n_rsp == n_exp && sb_q.size() == 0, "R2 one response per request",
        64'(n_rsp), 64'(n_exp));
    chk(addr_q.size() == 0, "R6 no extra reads", 64'(addr_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule